// File: doc/BRIEF.md
# Time-Slot Add/Drop Node for a Serial Multiplexed Link

This block sits on a one-way serial link that carries a frame of up to sixteen time slots, one bit per slot per frame. Each cycle of the shared fast clock moves the link forward by one slot. The node takes the link in on its fourth-input path and sends it out again, one register later, on its secondary output. It keeps a slot counter that a broadcast frame-sync pulse pulls back to slot 0. Nodes need no token to agree on slot numbers, so every node on the same sync stays aligned.

For each slot, a drop-enable mask and the slot numbers given to the local outputs decide whether the node copies the incoming bit to a local output. The copied value is held until the same slot comes round again. An add-enable mask and the slot numbers given to the local inputs decide whether the node puts a local bit in place of the incoming one. A slot that one node drops can therefore be refilled by that node, or by a later node, with a new signal. Chaining the last node back to the first closes the link into a ring.

Top module: `tdm_add_drop_node`

## Requirements
- R1: While `rst` is high at a clock edge, `link_out` and every `drop_data` bit become 0, and the slot counter returns to slot 0.
- R2: In a cycle with `frame_sync` high, the bit on `link_in` belongs to slot 0. In every other cycle the slot number is one more than in the cycle before, and it wraps from NUM_SLOTS-1 to 0.
- R3: When the current slot is not inserted, `link_out` in the next cycle equals `link_in` of the current cycle.
- R4: When `add_mask[s]` is 1 and `add_slot[i]` equals the current slot s, `link_out` in the next cycle equals `add_data[i]` of the current cycle.
- R5: An `add_slot[i]` that matches the current slot while `add_mask` for that slot is 0 has no effect: the incoming bit passes through.
- R6: When more than one local input maps to the same enabled slot, the input with the lowest index wins.
- R7: When `drop_mask[s]` is 1 and `drop_slot[j]` equals the current slot s, `drop_data[j]` in the next cycle equals `link_in` of the current cycle. Several outputs may drop the same slot.
- R8: `drop_data[j]` keeps its value in every cycle in which it is not loaded, including cycles where its slot matches but its `drop_mask` bit is 0.
- R9: When the same slot is both dropped and added, the local output receives the incoming bit and `link_out` carries the new local bit.
- R10: A `frame_sync` pulse that arrives in the middle of a frame realigns the counter at once, and every add and drop after it follows the new alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared fast slot clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | Broadcast pulse; marks that the current bit is slot 0 |
| link_in | input | 1 | Serial link input (fourth-input path) |
| add_mask | input | NUM_SLOTS | Per-slot add enable |
| add_slot | input | NUM_ADD x SLOT_W | Slot number for each local input |
| add_data | input | NUM_ADD | Local bits to insert |
| drop_mask | input | NUM_SLOTS | Per-slot drop enable |
| drop_slot | input | NUM_DROP x SLOT_W | Slot number for each local output |
| link_out | output | 1 | Serial link output (secondary output), one cycle behind |
| drop_data | output | NUM_DROP | Held values of the dropped slots |

## Verification
Random link bits with both masks clear show pure pass-through, and any wrong delay or leak from the local inputs shows up there. A single add slot with a sync every sixteen cycles, and then with no sync at all, tells correct wrap-around apart from a counter that stops or skips. Masked-off matches, two inputs on one slot, and an add and a drop on the same slot separate the enable, priority and reuse rules from each other. Syncs at irregular times, and a final random mix of configuration and data, show whether the node realigns and whether all the features still work together.

// File: rtl/tdm_node_pkg.sv
package tdm_node_pkg;

    localparam int unsigned DEF_SLOTS = 16;
    localparam int unsigned DEF_ADD   = 2;
    localparam int unsigned DEF_DROP  = 2;

    // Result of the insertion search for one slot.
    typedef struct packed {
        logic hit;
        logic value;
    } insert_t;

    // Width of a slot number for a given frame length.
    function automatic int unsigned slot_width(input int unsigned slots);
        return (slots > 1) ? $clog2(slots) : 1;
    endfunction

endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
    parameter int unsigned NUM_SLOTS = tdm_node_pkg::DEF_SLOTS,
    localparam int unsigned SLOT_W   = tdm_node_pkg::slot_width(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_sync,
    output logic [SLOT_W-1:0] cur_slot
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

    logic [SLOT_W-1:0] next_cnt;

    // The sync pulse names the present bit as slot 0.
    assign cur_slot = frame_sync ? '0 : next_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            next_cnt <= '0;
        end else if (cur_slot == LAST) begin
            next_cnt <= '0;
        end else begin
            next_cnt <= cur_slot + SLOT_W'(1);
        end
    end
endmodule

// File: rtl/tdm_insert_mux.sv
module tdm_insert_mux
    import tdm_node_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = DEF_SLOTS,
    parameter int unsigned NUM_ADD   = DEF_ADD,
    localparam int unsigned SLOT_W   = slot_width(NUM_SLOTS)
) (
    input  logic [SLOT_W-1:0]              cur_slot,
    input  logic [NUM_SLOTS-1:0]           add_mask,
    input  logic [NUM_ADD-1:0][SLOT_W-1:0] add_slot,
    input  logic [NUM_ADD-1:0]             add_data,
    input  logic                           link_in,
    output logic                           next_bit
);
    insert_t chain [NUM_ADD+1];

    // Ripple from the highest index down so the lowest index wins.
    assign chain[NUM_ADD] = '{hit: 1'b0, value: 1'b0};

    for (genvar i = NUM_ADD - 1; i >= 0; i--) begin : g_add
        logic match;
        assign match    = add_mask[cur_slot] && (add_slot[i] == cur_slot);
        assign chain[i] = match ? '{hit: 1'b1, value: add_data[i]} : chain[i+1];
    end

    assign next_bit = chain[0].hit ? chain[0].value : link_in;
endmodule

// File: rtl/tdm_drop_port.sv
module tdm_drop_port
    import tdm_node_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = DEF_SLOTS,
    localparam int unsigned SLOT_W   = slot_width(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SLOT_W-1:0]    cur_slot,
    input  logic [NUM_SLOTS-1:0] drop_mask,
    input  logic [SLOT_W-1:0]    my_slot,
    input  logic                 link_in,
    output logic                 held
);
    logic take;
    assign take = drop_mask[cur_slot] && (my_slot == cur_slot);

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= 1'b0;
        end else if (take) begin
            held <= link_in;
        end
    end
endmodule

// File: rtl/tdm_add_drop_node.sv
module tdm_add_drop_node
    import tdm_node_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = DEF_SLOTS,
    parameter int unsigned NUM_ADD   = DEF_ADD,
    parameter int unsigned NUM_DROP  = DEF_DROP,
    localparam int unsigned SLOT_W   = slot_width(NUM_SLOTS)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            frame_sync,
    input  logic                            link_in,
    input  logic [NUM_SLOTS-1:0]            add_mask,
    input  logic [NUM_ADD-1:0][SLOT_W-1:0]  add_slot,
    input  logic [NUM_ADD-1:0]              add_data,
    input  logic [NUM_SLOTS-1:0]            drop_mask,
    input  logic [NUM_DROP-1:0][SLOT_W-1:0] drop_slot,
    output logic                            link_out,
    output logic [NUM_DROP-1:0]             drop_data
);
    logic [SLOT_W-1:0] cur_slot;
    logic              next_bit;

    tdm_slot_timer #(.NUM_SLOTS(NUM_SLOTS)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .frame_sync(frame_sync),
        .cur_slot  (cur_slot)
    );

    tdm_insert_mux #(.NUM_SLOTS(NUM_SLOTS), .NUM_ADD(NUM_ADD)) u_ins (
        .cur_slot(cur_slot),
        .add_mask(add_mask),
        .add_slot(add_slot),
        .add_data(add_data),
        .link_in (link_in),
        .next_bit(next_bit)
    );

    for (genvar j = 0; j < NUM_DROP; j++) begin : g_drop
        tdm_drop_port #(.NUM_SLOTS(NUM_SLOTS)) u_port (
            .clk      (clk),
            .rst      (rst),
            .cur_slot (cur_slot),
            .drop_mask(drop_mask),
            .my_slot  (drop_slot[j]),
            .link_in  (link_in),
            .held     (drop_data[j])
        );
    end

    // One register stage on the link itself.
    always_ff @(posedge clk) begin
        if (rst) begin
            link_out <= 1'b0;
        end else begin
            link_out <= next_bit;
        end
    end
endmodule

// File: rtl/tdm_node_checker.sv
module tdm_node_checker #(
    parameter int unsigned NUM_SLOTS = 16,
    parameter int unsigned NUM_ADD   = 2,
    parameter int unsigned NUM_DROP  = 2,
    parameter int unsigned SLOT_W    = 4
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            frame_sync,
    input logic                            link_in,
    input logic [NUM_SLOTS-1:0]            add_mask,
    input logic [NUM_ADD-1:0][SLOT_W-1:0]  add_slot,
    input logic [NUM_ADD-1:0]              add_data,
    input logic [NUM_SLOTS-1:0]            drop_mask,
    input logic [NUM_DROP-1:0][SLOT_W-1:0] drop_slot,
    input logic                            link_out,
    input logic [NUM_DROP-1:0]             drop_data,
    input logic [SLOT_W-1:0]               cur_slot
);
    logic seen;
    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    // R2: the slot number steps by one between syncs
    assert_slot_step_R2: assert property (@(posedge clk) disable iff (rst)
        (seen && !frame_sync) |->
            (int'(cur_slot) == ((int'($past(cur_slot)) + 1) % NUM_SLOTS)));

    // R3: a slot with no add enable leaves the link bit unchanged
    assert_pass_through_R3: assert property (@(posedge clk) disable iff (rst)
        !add_mask[cur_slot] |=> (link_out == $past(link_in)));

    // R4: input 0 always wins its enabled slot
    assert_insert_R4: assert property (@(posedge clk) disable iff (rst)
        (add_mask[cur_slot] && add_slot[0] == cur_slot) |=>
            (link_out == $past(add_data[0])));

    // R8: a slot with no drop enable changes no local output
    assert_drop_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !drop_mask[cur_slot] |=> $stable(drop_data));

    // R7: output 0 loads the incoming bit of its enabled slot
    assert_drop_load_R7: assert property (@(posedge clk) disable iff (rst)
        (drop_mask[cur_slot] && drop_slot[0] == cur_slot) |=>
            (drop_data[0] == $past(link_in)));

    // Immediate check that the reset state is clean, for R1.
    always @(negedge clk) begin
        if (seen === 1'b0 && $past(rst)) begin
            assert_reset_state_R1: assert (link_out == 1'b0 && drop_data == '0);
        end
    end
endmodule

bind tdm_add_drop_node tdm_node_checker #(
    .NUM_SLOTS(NUM_SLOTS),
    .NUM_ADD  (NUM_ADD),
    .NUM_DROP (NUM_DROP),
    .SLOT_W   (SLOT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .frame_sync(frame_sync),
    .link_in   (link_in),
    .add_mask  (add_mask),
    .add_slot  (add_slot),
    .add_data  (add_data),
    .drop_mask (drop_mask),
    .drop_slot (drop_slot),
    .link_out  (link_out),
    .drop_data (drop_data),
    .cur_slot  (cur_slot)
);

// File: tb/sim_tdm_add_drop_node.sv
module sim_tdm_add_drop_node;
    localparam int PERIOD = 10;
    localparam int NS = 16;
    localparam int NA = 2;
    localparam int ND = 2;
    localparam int SW = 4;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    frame_sync = 1'b0;
    logic                    link_in = 1'b0;
    logic [NS-1:0]           add_mask = '0;
    logic [NA-1:0][SW-1:0]   add_slot = '0;
    logic [NA-1:0]           add_data = '0;
    logic [NS-1:0]           drop_mask = '0;
    logic [ND-1:0][SW-1:0]   drop_slot = '0;
    logic                    link_out;
    logic [ND-1:0]           drop_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string tag = "R1";

    // Reference model state
    int   m_cnt = 0;
    logic m_out = 1'b0;
    logic m_drop [ND];

    tdm_add_drop_node #(.NUM_SLOTS(NS), .NUM_ADD(NA), .NUM_DROP(ND)) u0 (
        .clk(clk), .rst(rst), .frame_sync(frame_sync), .link_in(link_in),
        .add_mask(add_mask), .add_slot(add_slot), .add_data(add_data),
        .drop_mask(drop_mask), .drop_slot(drop_slot),
        .link_out(link_out), .drop_data(drop_data)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Model the edge from the inputs now applied.
    task automatic model_edge();
        int cur;
        int win;
        if (rst) begin
            m_cnt = 0;
            m_out = 1'b0;
            for (int j = 0; j < ND; j++) m_drop[j] = 1'b0;
            return;
        end
        cur = frame_sync ? 0 : m_cnt;
        m_cnt = (cur + 1) % NS;
        win = -1;
        if (add_mask[cur]) begin
            for (int i = NA - 1; i >= 0; i--)
                if (int'(add_slot[i]) == cur) win = i;
        end
        for (int j = 0; j < ND; j++)
            if (drop_mask[cur] && int'(drop_slot[j]) == cur) m_drop[j] = link_in;
        m_out = (win >= 0) ? add_data[win] : link_in;
    endtask

    task automatic tick(input logic sync);
        frame_sync = sync;
        model_edge();
        @(posedge clk);
        @(negedge clk);
        chk(tag, "link_out", link_out, m_out);
        for (int j = 0; j < ND; j++) chk(tag, $sformatf("drop_data[%0d]", j), drop_data[j], m_drop[j]);
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int j = 0; j < ND; j++) m_drop[j] = 1'b0;
        @(negedge clk);
        tag = "R1";
        link_in = 1'b1;
        add_mask = '1;
        add_data = '1;
        tick(1'b0);
        tick(1'b0);
        rst = 1'b0;
        add_mask = '0;

        // R3: pure pass-through of random bits
        tag = "R3";
        for (int k = 0; k < 40; k++) begin
            link_in = 1'($urandom);
            add_data = NA'($urandom);
            tick(k % NS == 0);
        end

        // R4 and R2: one add slot, synced framing then free running wrap
        tag = "R4";
        add_mask[5] = 1'b1;
        add_slot[0] = 4'd5;
        for (int k = 0; k < 48; k++) begin
            link_in = 1'b0;
            add_data[0] = ~add_data[0];
            tick(k % NS == 0);
        end
        tag = "R2";
        for (int k = 0; k < 50; k++) begin
            link_in = 1'($urandom);
            add_data = NA'($urandom);
            tick(1'b0);
        end

        // R5: input 1 maps to slot 9 whose add bit is clear
        tag = "R5";
        add_mask = '0;
        add_slot[1] = 4'd9;
        for (int k = 0; k < 32; k++) begin
            link_in = 1'($urandom);
            add_data = NA'($urandom);
            tick(k == 0);
        end

        // R6: both inputs on slot 3, input 0 holds 0, input 1 holds 1
        tag = "R6";
        add_mask = '0;
        add_mask[3] = 1'b1;
        add_slot[0] = 4'd3;
        add_slot[1] = 4'd3;
        for (int k = 0; k < 32; k++) begin
            link_in = 1'b1;
            add_data = 2'b10;
            tick(k == 0);
        end

        // R7 and R8: output 0 drops slot 7, output 1 names slot 2 with no enable
        tag = "R7";
        add_mask = '0;
        drop_mask = '0;
        drop_mask[7] = 1'b1;
        drop_slot[0] = 4'd7;
        drop_slot[1] = 4'd2;
        for (int k = 0; k < 64; k++) begin
            link_in = 1'($urandom);
            tick(k % NS == 0);
        end
        tag = "R8";
        drop_slot[1] = 4'd7;
        drop_mask[7] = 1'b0;
        for (int k = 0; k < 32; k++) begin
            link_in = 1'($urandom);
            tick(k % NS == 0);
        end

        // R9: slot 11 dropped and refilled by the same node
        tag = "R9";
        drop_mask = '0;
        drop_mask[11] = 1'b1;
        drop_slot[0] = 4'd11;
        drop_slot[1] = 4'd11;
        add_mask = '0;
        add_mask[11] = 1'b1;
        add_slot[0] = 4'd11;
        for (int k = 0; k < 64; k++) begin
            link_in = 1'($urandom);
            add_data = NA'($urandom);
            tick(k % NS == 0);
        end

        // R10: syncs at irregular points
        tag = "R10";
        for (int k = 0; k < 200; k++) begin
            link_in = 1'($urandom);
            add_data = NA'($urandom);
            tick(($urandom % 11) == 0);
        end

        // Mixed random configuration
        tag = "R4";
        for (int k = 0; k < 2000; k++) begin
            if (k % 64 == 0) begin
                add_mask = NS'($urandom);
                drop_mask = NS'($urandom);
                add_slot = (NA*SW)'($urandom);
                drop_slot = (ND*SW)'($urandom);
            end
            link_in = 1'($urandom);
            add_data = NA'($urandom);
            tick(($urandom % 20) == 0);
        end

        // R1: reset in the middle of traffic clears the outputs
        tag = "R1";
        rst = 1'b1;
        link_in = 1'b1;
        tick(1'b0);
        rst = 1'b0;
        add_mask = '0;
        tick(1'b0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule